// File: doc/BRIEF.md
# Three-Channel PWM Controller with AXI4-Lite Register Access

This block drives three pulse-width-modulated lines, meant for the red, green and blue dies of an RGB LED. A processor programs the block through an AXI4-Lite slave port. Each channel has its own 10-bit duty word. One packed control word turns each channel on or off. When a channel is off, its line is held low.

Only the red channel has programmable timing. A power-of-two tick divider sets the rate at which its window counter advances, and a window-limit register sets how many ticks make up one window. The green and blue channels use fixed timing: the counter advances every second clock, and a window is 1024 ticks long. Within a window, a channel's line is high while its counter is below its duty value.

The bus side is a single state machine with these states:
- `AX_IDLE` accepts a write address, write data or a read address.
- `AX_HAVE_ADDR` holds a write address while it waits for the data.
- `AX_HAVE_DATA` holds write data while it waits for the address.
- `AX_WRESP` presents the write response.
- `AX_RDATA` presents the read data.

Its transitions are:
- From `AX_IDLE`:
  - To `AX_WRESP` when address and data arrive together.
  - To `AX_HAVE_ADDR` when only the address arrives.
  - To `AX_HAVE_DATA` when only the data arrives.
  - To `AX_RDATA` when a read address is accepted with no write pending.
- To `AX_WRESP` from `AX_HAVE_ADDR` when the data arrives, and from `AX_HAVE_DATA` when the address arrives.
- From `AX_WRESP` to `AX_IDLE` on `bready`.
- From `AX_RDATA` to `AX_IDLE` on `rready`.

A write has priority over a read in `AX_IDLE`.

Top module: `rgb_pwm_axil`

## Requirements
- R1: After reset, all three PWM outputs are low. The duty, enable and divider registers read zero, and the window-limit register reads 1023.
- R2: Duty words live at byte offset 0 (red), 4 (green) and 8 (blue), in bits 9:0. A written value reads back unchanged.
- R3: The enable word is at offset 12. Bit 0 enables red, bit 1 enables green and bit 2 enables blue. A channel whose bit is clear outputs a constant 0.
- R4: For an enabled channel with a window of W ticks, the output is high for min(duty, W) ticks of every window. Green and blue use W = 1024 with one tick every 2 clocks, so one window is 2048 clocks.
- R5: The divider select at offset 16 (bits 3:0) makes the red counter advance once every 2^(sel+1) clocks. Green and blue are unaffected by it.
- R6: The window limit at offset 20 (bits 9:0) sets the red window to limit+1 ticks. Green and blue are unaffected by it.
- R7: Register bits outside the listed fields read as zero. Offsets 24 to 31 read as zero and ignore writes.
- R8: Write strobe bit 0 gates bits 7:0 and strobe bit 1 gates bits 15:8. Bytes whose strobe is clear keep their old value.
- R9: A write takes effect only after both the address and the data handshakes, in either order. The write then returns `bresp` = 0 (OKAY), and `bvalid` stays high until `bready`.
- R10: Read data and `rvalid` = 1 appear in the cycle after the read address is accepted, with `rresp` = 0. `rvalid` and `rdata` hold until `rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 5 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 5 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| pwm_o | output | 3 | PWM lines: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench builds the block with its default parameters: a 10-bit duty, a 4-bit divider select and a 5-bit address. With those defaults a full green or blue window is only 2048 clocks, so exact high-time counts over a complete window fit easily in the run. Shrinking the red window to 10 ticks, with divider selects 0 and 2, makes red windows of 20 and 80 clocks. That brings the duty-above-window saturation case and the divider scaling within reach in a few hundred cycles.

// File: rtl/rgbpwm_pkg.sv
package rgbpwm_pkg;
    localparam int NUM_CH   = 3;
    localparam int DUTY_W   = 10;
    localparam int SEL_W    = 4;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int STRB_W   = DATA_W / 8;
    localparam int IDX_W    = ADDR_W - 2;

    // word indices; index = byte offset / 4
    localparam logic [IDX_W-1:0] IDX_DUTY0 = 3'd0;
    localparam logic [IDX_W-1:0] IDX_ENA   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DIV   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_WIN   = 3'd5;

    localparam logic [DUTY_W-1:0] WIN_FULL = {DUTY_W{1'b1}};

    typedef enum logic [2:0] {
        AX_IDLE,
        AX_HAVE_ADDR,
        AX_HAVE_DATA,
        AX_WRESP,
        AX_RDATA
    } ax_state_e;

    typedef struct packed {
        logic                 en;
        logic [IDX_W-1:0]     idx;
        logic                 aligned;
        logic [15:0]          data;
        logic [1:0]           strb;
    } wr_req_t;
endpackage

// File: rtl/rgbpwm_axil_slave.sv
module rgbpwm_axil_slave
    import rgbpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output wr_req_t           wr,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    ax_state_e state_q, state_d;
    logic [ADDR_W-1:0] awaddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [STRB_W-1:0] wstrb_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ar_take;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AX_IDLE: begin
                if (awvalid && wvalid) state_d = AX_WRESP;
                else if (awvalid)      state_d = AX_HAVE_ADDR;
                else if (wvalid)       state_d = AX_HAVE_DATA;
                else if (arvalid)      state_d = AX_RDATA;
            end
            AX_HAVE_ADDR: if (wvalid)  state_d = AX_WRESP;
            AX_HAVE_DATA: if (awvalid) state_d = AX_WRESP;
            AX_WRESP:     if (bready)  state_d = AX_IDLE;
            AX_RDATA:     if (rready)  state_d = AX_IDLE;
            default:                   state_d = AX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        arready = 1'b0;
        bvalid  = 1'b0;
        rvalid  = 1'b0;
        wr.en   = 1'b0;
        unique case (state_q)
            AX_IDLE: begin
                awready = 1'b1;
                wready  = 1'b1;
                arready = !awvalid && !wvalid;
                wr.en   = awvalid && wvalid;
            end
            AX_HAVE_ADDR: begin
                wready = 1'b1;
                wr.en  = wvalid;
            end
            AX_HAVE_DATA: begin
                awready = 1'b1;
                wr.en   = awvalid;
            end
            AX_WRESP: bvalid = 1'b1;
            AX_RDATA: rvalid = 1'b1;
            default: ;
        endcase
    end

    assign ar_take = arready && arvalid;
    assign wr_addr = (state_q == AX_HAVE_ADDR) ? awaddr_q : awaddr;
    assign wr_data = (state_q == AX_HAVE_DATA) ? wdata_q : wdata;
    assign wr_strb = (state_q == AX_HAVE_DATA) ? wstrb_q : wstrb;

    assign wr.idx     = wr_addr[ADDR_W-1:2];
    assign wr.aligned = (wr_addr[1:0] == 2'b00);
    assign wr.data    = wr_data[15:0];
    assign wr.strb    = wr_strb[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awaddr_q <= '0;
            wdata_q  <= '0;
            wstrb_q  <= '0;
            rdata_q  <= '0;
        end else begin
            if (awvalid && awready) awaddr_q <= awaddr;
            if (wvalid && wready) begin
                wdata_q <= wdata;
                wstrb_q <= wstrb;
            end
            if (ar_take) rdata_q <= rd_data;
        end
    end

    assign rd_addr = araddr;
    assign rdata   = rdata_q;
    assign bresp   = 2'b00;
    assign rresp   = 2'b00;

    a_r9_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    a_r9_resp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bvalid) |-> $past(wvalid && wready) || $past(awvalid && awready));
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
    a_r10_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> rvalid);
endmodule

// File: rtl/rgbpwm_regfile.sv
module rgbpwm_regfile
    import rgbpwm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  wr_req_t                       wr,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_CH-1:0][DUTY_W-1:0] duty,
    output logic [NUM_CH-1:0]             ena,
    output logic [SEL_W-1:0]              div_sel,
    output logic [DUTY_W-1:0]             win_lim
);
    logic [IDX_W-1:0] rd_idx;

    function automatic logic [DUTY_W-1:0] merge10(input logic [DUTY_W-1:0] old,
                                                 input logic [15:0] d,
                                                 input logic [1:0] s);
        logic [15:0] r;
        r = {6'b0, old};
        if (s[0]) r[7:0]  = d[7:0];
        if (s[1]) r[15:8] = d[15:8];
        return r[DUTY_W-1:0];
    endfunction

    for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
        always_ff @(posedge clk) begin
            if (!rst_n) duty[c] <= '0;
            else if (wr.en && wr.aligned && wr.idx == IDX_DUTY0 + IDX_W'(c))
                duty[c] <= merge10(duty[c], wr.data, wr.strb);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena     <= '0;
            div_sel <= '0;
            win_lim <= WIN_FULL;
        end else if (wr.en && wr.aligned && wr.strb[0]) begin
            if (wr.idx == IDX_ENA) ena     <= wr.data[NUM_CH-1:0];
            if (wr.idx == IDX_DIV) div_sel <= wr.data[SEL_W-1:0];
            if (wr.en && wr.idx == IDX_WIN) win_lim <= merge10(win_lim, wr.data, wr.strb);
        end else if (wr.en && wr.aligned && wr.idx == IDX_WIN) begin
            win_lim <= merge10(win_lim, wr.data, wr.strb);
        end
    end

    assign rd_idx = rd_addr[ADDR_W-1:2];

    always_comb begin
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00) begin
            unique case (rd_idx)
                3'd0, 3'd1, 3'd2: rd_data[DUTY_W-1:0] = duty[rd_idx[1:0]];
                IDX_ENA: rd_data[NUM_CH-1:0] = ena;
                IDX_DIV: rd_data[SEL_W-1:0]  = div_sel;
                IDX_WIN: rd_data[DUTY_W-1:0] = win_lim;
                default: rd_data = '0;
            endcase
        end
    end

    a_r7_ignored_offset: assert property (@(posedge clk) disable iff (!rst_n)
        wr.en && wr.idx > IDX_WIN |=> $stable(duty) && $stable(ena) && $stable(div_sel) && $stable(win_lim));
endmodule

// File: rtl/rgbpwm_tick_gen.sv
module rgbpwm_tick_gen
    import rgbpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 1 << SEL_W;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign mask = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(sel));
    assign tick = (cnt_q & mask) == mask;
endmodule

// File: rtl/rgbpwm_channel.sv
module rgbpwm_channel
    import rgbpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] win_lim,
    output logic              pwm
);
    logic [DUTY_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            pwm   <= 1'b0;
        end else begin
            if (tick) pos_q <= (pos_q >= win_lim) ? '0 : pos_q + 1'b1;
            pwm <= en && (pos_q < duty);
        end
    end

    a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm);
    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        duty == '0 |=> !pwm);
endmodule

// File: rtl/rgb_pwm_axil.sv
module rgb_pwm_axil
    import rgbpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [NUM_CH-1:0] pwm_o
);
    wr_req_t                       wr;
    logic [ADDR_W-1:0]             rd_addr;
    logic [DATA_W-1:0]             rd_data;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty;
    logic [NUM_CH-1:0]             ena;
    logic [SEL_W-1:0]              div_sel;
    logic [DUTY_W-1:0]             win_lim;

    rgbpwm_axil_slave u_bus (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .wr(wr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rgbpwm_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .duty(duty), .ena(ena), .div_sel(div_sel), .win_lim(win_lim)
    );

    // channel 0 takes the programmable timing, the rest run fixed
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             tick;
        logic [SEL_W-1:0] sel_c;
        logic [DUTY_W-1:0] lim_c;
        if (c == 0) begin : g_prog
            assign sel_c = div_sel;
            assign lim_c = win_lim;
        end else begin : g_fixed
            assign sel_c = '0;
            assign lim_c = WIN_FULL;
        end
        rgbpwm_tick_gen u_tick (
            .clk(clk), .rst_n(rst_n), .sel(sel_c), .tick(tick)
        );
        rgbpwm_channel u_pwm (
            .clk(clk), .rst_n(rst_n), .tick(tick), .en(ena[c]),
            .duty(duty[c]), .win_lim(lim_c), .pwm(pwm_o[c])
        );
    end
endmodule

// File: tb/rgb_pwm_axil_tb.sv
module rgb_pwm_axil_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [4:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [2:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rgb_pwm_axil u_dut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic axi_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s,
                             output logic [1:0] resp);
        @(negedge clk);
        s_awaddr = a; s_awvalid = 1'b1;
        s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
        while (s_awvalid || s_wvalid) begin
            bit aw_hs, w_hs;
            #1;
            aw_hs = s_awvalid && s_awready;
            w_hs  = s_wvalid && s_wready;
            @(posedge clk); #1;
            if (aw_hs) s_awvalid = 1'b0;
            if (w_hs)  s_wvalid = 1'b0;
        end
        s_bready = 1'b1;
        forever begin
            bit got;
            got = s_bvalid;
            resp = s_bresp;
            @(posedge clk); #1;
            if (got) break;
        end
        s_bready = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [1:0] r;
        axi_write(a, d, 4'hF, r);
    endtask

    task automatic axi_read(input logic [4:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        while (s_arvalid) begin
            bit hs;
            #1;
            hs = s_arready;
            @(posedge clk); #1;
            if (hs) s_arvalid = 1'b0;
        end
        s_rready = 1'b1;
        forever begin
            bit got;
            got = s_rvalid;
            d = s_rdata;
            resp = s_rresp;
            @(posedge clk); #1;
            if (got) break;
        end
        s_rready = 1'b0;
    endtask

    function automatic logic [31:0] dummy(input logic [31:0] x);
        return x;
    endfunction

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        logic [1:0] r;
        axi_read(a, d, r);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(pwm_o == 3'b000, "R1 outputs low", pwm_o, 0);
        for (int i = 0; i < 5; i++) begin
            rd(5'(i * 4), d);
            check(d == 0, "R1 reg zero", d, 0);
        end
        rd(5'd20, d);
        check(d == 1023, "R1 window reset", d, 1023);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(5'd0, 32'h123); wr(5'd4, 32'h2A5); wr(5'd8, 32'h3FF);
        rd(5'd0, d); check(d == 32'h123, "R2 red readback", d, 32'h123);
        rd(5'd4, d); check(d == 32'h2A5, "R2 green readback", d, 32'h2A5);
        rd(5'd8, d); check(d == 32'h3FF, "R2 blue readback", d, 32'h3FF);
    endtask

    task automatic t_enables();
        int hi;
        wr(5'd0, 300); wr(5'd4, 300); wr(5'd8, 300);
        wr(5'd12, 32'h2);
        repeat (50) @(negedge clk);
        count_high(0, 2048, hi); check(hi == 0, "R3 red off", hi, 0);
        count_high(1, 2048, hi); check(hi == 600, "R3 green on", hi, 600);
        count_high(2, 2048, hi); check(hi == 0, "R3 blue off", hi, 0);
    endtask

    task automatic t_duty();
        int hi;
        wr(5'd12, 32'h7);
        wr(5'd8, 1023);
        repeat (50) @(negedge clk);
        count_high(2, 2048, hi); check(hi == 2046, "R4 blue near full", hi, 2046);
        wr(5'd4, 0);
        repeat (50) @(negedge clk);
        count_high(1, 2048, hi); check(hi == 0, "R4 green zero duty", hi, 0);
        wr(5'd4, 300);
    endtask

    task automatic t_red_timing();
        int hi;
        wr(5'd20, 9); wr(5'd16, 2); wr(5'd0, 3);
        repeat (200) @(negedge clk);
        count_high(0, 80, hi);   check(hi == 24, "R5 red div sel 2", hi, 24);
        count_high(1, 2048, hi); check(hi == 600, "R6 green untouched", hi, 600);
        wr(5'd0, 20);
        repeat (200) @(negedge clk);
        count_high(0, 80, hi);   check(hi == 80, "R4 duty above window", hi, 80);
        wr(5'd0, 3); wr(5'd16, 0);
        repeat (200) @(negedge clk);
        count_high(0, 40, hi);   check(hi == 12, "R5 red div sel 0", hi, 12);
        count_high(2, 2048, hi); check(hi == 2046, "R5 blue untouched", hi, 2046);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        wr(5'd0, 32'hFFFF_FFFF);
        rd(5'd0, d);  check(d == 32'h3FF, "R7 duty upper bits", d, 32'h3FF);
        wr(5'd12, 32'hFFFF_FFF8);
        rd(5'd12, d); check(d == 0, "R7 enable upper bits", d, 0);
        wr(5'd16, 32'hFFFF_FFFF);
        rd(5'd16, d); check(d == 32'hF, "R7 div upper bits", d, 32'hF);
        wr(5'd24, 32'h5);
        rd(5'd24, d); check(d == 0, "R7 unmapped read", d, 0);
        rd(5'd12, d); check(d == 0, "R7 unmapped write ignored", d, 0);
        wr(5'd16, 0); wr(5'd12, 7);
    endtask

    task automatic t_strobes();
        logic [31:0] d;
        logic [1:0] r;
        wr(5'd4, 32'h155);
        axi_write(5'd4, 32'h2AA, 4'b0001, r);
        rd(5'd4, d); check(d == 32'h1AA, "R8 low lane", d, 32'h1AA);
        axi_write(5'd4, 32'h300, 4'b0010, r);
        rd(5'd4, d); check(d == 32'h3AA, "R8 high lane", d, 32'h3AA);
        axi_write(5'd4, 32'h0, 4'b0000, r);
        rd(5'd4, d); check(d == 32'h3AA, "R8 no lane", d, 32'h3AA);
    endtask

    task automatic t_write_order();
        logic [31:0] d;
        // address first
        @(negedge clk);
        s_awaddr = 5'd8; s_awvalid = 1'b1;
        @(posedge clk); #1; s_awvalid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!s_bvalid, "R9 no resp before data", s_bvalid, 0);
        end
        s_wdata = 32'h0AB; s_wstrb = 4'hF; s_wvalid = 1'b1;
        @(posedge clk); #1; s_wvalid = 1'b0;
        @(negedge clk);
        check(s_bvalid && s_bresp == 0, "R9 resp after data", s_bvalid, 1);
        repeat (2) @(negedge clk);
        check(s_bvalid, "R9 bvalid held", s_bvalid, 1);
        s_bready = 1'b1;
        @(posedge clk); #1; s_bready = 1'b0;
        rd(5'd8, d); check(d == 32'h0AB, "R9 aw-first value", d, 32'h0AB);
        // data first
        @(negedge clk);
        s_wdata = 32'h0CD; s_wstrb = 4'hF; s_wvalid = 1'b1;
        @(posedge clk); #1; s_wvalid = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check(!s_bvalid, "R9 no resp before addr", s_bvalid, 0);
        end
        s_awaddr = 5'd8; s_awvalid = 1'b1;
        @(posedge clk); #1; s_awvalid = 1'b0;
        s_bready = 1'b1;
        @(negedge clk);
        check(s_bvalid && s_bresp == 0, "R9 resp after addr", s_bvalid, 1);
        @(posedge clk); #1; s_bready = 1'b0;
        rd(5'd8, d); check(d == 32'h0CD, "R9 w-first value", d, 32'h0CD);
    endtask

    task automatic t_read_timing();
        logic [31:0] first;
        @(negedge clk);
        s_araddr = 5'd8; s_arvalid = 1'b1;
        #1;
        check(s_arready && !s_rvalid, "R10 idle before accept", s_rvalid, 0);
        @(posedge clk); #1; s_arvalid = 1'b0;
        check(s_rvalid && s_rresp == 0, "R10 rvalid next cycle", s_rvalid, 1);
        first = s_rdata;
        check(first == 32'h0CD, "R10 data", first, 32'h0CD);
        repeat (3) @(negedge clk);
        check(s_rvalid && s_rdata == first, "R10 held until rready", s_rdata, first);
        s_rready = 1'b1;
        @(posedge clk); #1; s_rready = 1'b0;
        @(negedge clk);
        check(!s_rvalid, "R10 released", s_rvalid, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_enables();
        t_duty();
        t_red_timing();
        t_unused();
        t_strobes();
        t_write_order();
        t_read_timing();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule